// File: doc/BRIEF.md
# Bit-Serial Scaled-Term Adder Stage

This block is one arithmetic stage of a bit-serial recursive filter loop. Two operand streams arrive in two's complement, least-significant bit first, one bit per clock, and each word takes `W` clocks. The block adds operand `a` to operand `b` scaled by the power-of-two coefficient 2^-K. It returns the sum as a serial stream with the same framing, wrapped to `W` bits. The scaling needs no multiplier. It comes from delaying `a` by `K` bit times and reading `b` `K` bits later in its frame.

The top `K` bits of the scaled term do not exist in the incoming `b` word. A hold register fills them by repeating the last scaled bit it passed on, which is the sign bit of `b`. The result is truncation of the scaled term toward minus infinity, with no separate quantizer. A free-running modulo-`W` phase counter times the input frames and drives two controls: the extend window for the hold register, and the clear of the adder's stored carry at the start of each output word. Several such stages can be chained, with each stage's output framing lining up with the next stage's input.

Top module: `bsx_scaled_adder`

## Requirements
- R1: After reset the phase counter starts at phase 0. `word_sync` is 1 in exactly one cycle of every `W`, namely the cycles in which the LSB of an input word must be presented on `a_bit` and `b_bit`. It is 1 in the first cycle after reset.
- R2: Each output word equals (a + floor(b / 2^K)) modulo 2^W, read as a `W`-bit two's complement value, where a and b are the input words presented in the same frame.
- R3: Bit i of the output word appears on `y_bit` K+1 cycles after bit i of the input word was presented. `y_sof` is 1 exactly in the cycles that carry bit 0 of an output word.
- R4: The adder's stored carry is cleared at each output word start. A carry out of the top bit of one word never changes the next word.
- R5: The upper K bits of the scaled term are all copies of the sign bit (bit W-1) of the `b` word, produced by holding the previously passed bit.
- R6: While `rst` is high, `y_bit` and `y_sof` are 0 and the phase counter is held at phase 0, so `word_sync` is 1.
- R7: The scaled term rounds toward minus infinity. A negative `b` whose low K bits are not zero gives a term one below its value truncated toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| a_bit | input | 1 | Serial unscaled operand, LSB first |
| b_bit | input | 1 | Serial operand scaled by 2^-K, LSB first |
| word_sync | output | 1 | High when an input word's LSB is due |
| y_bit | output | 1 | Serial sum, LSB first |
| y_sof | output | 1 | High while `y_bit` carries an output word's LSB |

## Verification
The stage is driven first with directed word pairs, then with random pairs. A `b` of -1 and a `b` of the most negative value show whether the extend window repeats the sign rather than the next word's low bits. A positive `a` near full scale wraps, which checks the modulo behaviour. An `a` of -1 with a `b` that scales to +1 produces a carry out of the top bit, and the word after it is all zeros, which exposes a carry that leaks across words. Small negative `b` values with nonzero low bits separate floor from truncation toward zero. The random pairs then cover general carry chains. The reference compares every output bit, as well as `y_sof` and `word_sync`, on every clock.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

    // Control decoded from the input-frame phase.
    typedef struct packed {
        logic word_start; // input LSB due this cycle
        logic extend;     // scaled term repeats its held bit
        logic carry_clr;  // output word bit 0 is being summed
    } bsx_ctl_t;

    // State produced by one bit of serial addition.
    typedef struct packed {
        logic sum;
        logic carry;
    } bsx_add_t;

    function automatic bsx_ctl_t bsx_decode(input int phase, input int k);
        bsx_ctl_t c;
        c.word_start = (phase == 0);
        c.extend     = (phase < k);
        c.carry_clr  = (phase == k);
        return c;
    endfunction

    function automatic bsx_add_t bsx_full_add(input logic x, input logic y, input logic ci);
        bsx_add_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

    // Cycles from an input bit to the matching output bit.
    function automatic int bsx_latency(input int k);
        return k + 1;
    endfunction

endpackage

// File: rtl/bsx_framer.sv
module bsx_framer
    import bsx_pkg::*;
#(
    parameter int W = 12,
    parameter int K = 2
) (
    input  logic     clk,
    input  logic     rst,
    output bsx_ctl_t ctl
);
    localparam int PW = (W > 1) ? $clog2(W) : 1;
    localparam logic [PW-1:0] LAST = PW'(W - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                 phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    always_comb ctl = bsx_decode(int'(phase_q), K);

    p_phase_range_r1: assert property (@(posedge clk) disable iff (rst)
        int'(phase_q) < W);
    p_sync_gap_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.word_start |=> !ctl.word_start);
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_q == LAST) |=> ctl.word_start);
endmodule

// File: rtl/bsx_delay.sv
module bsx_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_line
            logic [DEPTH-1:0] sr_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr_q <= '0;
                end else begin
                    sr_q[0] <= din;
                    for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
                end
            end
            assign dout = sr_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/bsx_stage.sv
module bsx_stage
    import bsx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bsx_ctl_t ctl,
    input  logic     a_dly,
    input  logic     b_bit,
    output logic     y_bit,
    output logic     y_sof
);
    logic     hold_q;
    logic     carry_q;
    logic     y_q;
    logic     sof_q;
    logic     term;
    logic     cin;
    bsx_add_t fa;

    // Scaled term: live operand bit, or the held sign while extending.
    always_comb begin
        term = ctl.extend ? hold_q : b_bit;
        cin  = ctl.carry_clr ? 1'b0 : carry_q;
        fa   = bsx_full_add(a_dly, term, cin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= 1'b0;
            carry_q <= 1'b0;
            y_q     <= 1'b0;
            sof_q   <= 1'b0;
        end else begin
            hold_q  <= term;
            carry_q <= fa.carry;
            y_q     <= fa.sum;
            sof_q   <= ctl.carry_clr;
        end
    end

    assign y_bit = y_q;
    assign y_sof = sof_q;

    p_carry_fresh_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.carry_clr |=> (carry_q == $past(a_dly & term)));
    p_hold_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.extend && !ctl.word_start) |-> $stable(hold_q));
    p_sof_single_r3: assert property (@(posedge clk) disable iff (rst)
        y_sof |=> !y_sof);
endmodule

// File: rtl/bsx_scaled_adder.sv
module bsx_scaled_adder
    import bsx_pkg::*;
#(
    parameter int W = 12,
    parameter int K = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_bit,
    input  logic b_bit,
    output logic word_sync,
    output logic y_bit,
    output logic y_sof
);
    localparam int LAT = bsx_latency(K);

    bsx_ctl_t ctl;
    logic     a_dly;

    bsx_framer #(.W(W), .K(K)) u_framer (
        .clk (clk),
        .rst (rst),
        .ctl (ctl)
    );

    bsx_delay #(.DEPTH(K)) u_align (
        .clk  (clk),
        .rst  (rst),
        .din  (a_bit),
        .dout (a_dly)
    );

    bsx_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .a_dly (a_dly),
        .b_bit (b_bit),
        .y_bit (y_bit),
        .y_sof (y_sof)
    );

    assign word_sync = ctl.word_start;

    initial begin
        assert (K >= 0 && K < W && W >= 2 && LAT == K + 1)
            else $error("bsx_scaled_adder: need W >= 2 and 0 <= K < W");
    end

    p_reset_quiet_r6: assert property (@(posedge clk)
        rst |=> (!y_bit && !y_sof));
endmodule

// File: tb/sim_bsx_scaled_adder.sv
module sim_bsx_scaled_adder;
    localparam int W      = 12;
    localparam int K      = 2;
    localparam int NW     = 320;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_bit = 1'b0;
    logic b_bit = 1'b0;
    logic word_sync, y_bit, y_sof;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] av [NW];
    logic [W-1:0] bv [NW];
    logic [W-1:0] ev [NW];

    bsx_scaled_adder #(.W(W), .K(K)) u0 (
        .clk(clk), .rst(rst), .a_bit(a_bit), .b_bit(b_bit),
        .word_sync(word_sync), .y_bit(y_bit), .y_sof(y_sof)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp, input int at);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at step %0d: actual %b expected %b", req, at, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [W-1:0] sb;
        logic [W-1:0] sc;
        sb = b;
        sc = sb >>> K;   // floor division by 2^K
        return a + sc;   // wraps modulo 2^W
    endfunction

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // directed pairs, then random
        av[0] = '0;           bv[0] = '1;                 // R5: -1 scaled stays -1
        av[1] = '0;           bv[1] = {1'b1, {(W-1){1'b0}}}; // R5: most negative
        av[2] = {1'b0, {(W-1){1'b1}}}; bv[2] = {1'b0, {(W-1){1'b1}}}; // R2 wrap
        av[3] = '1;           bv[3] = W'(1 << K);         // R4: carry out of top
        av[4] = '0;           bv[4] = '0;                 // R4: must read zero
        av[5] = W'(5);        bv[5] = W'(-5);             // R7: floor gives -2
        av[6] = '0;           bv[6] = W'(-1 - (1 << K));  // R7
        av[7] = '1;           bv[7] = '1;
        for (int i = 8; i < NW; i++) begin
            av[i] = W'($urandom);
            bv[i] = W'($urandom);
        end
        for (int i = 0; i < NW; i++) ev[i] = ref_sum(av[i], bv[i]);

        // R6: reset state
        repeat (3) begin
            @(negedge clk);
            check("R6 y_bit", y_bit, 1'b0, -1);
            check("R6 y_sof", y_sof, 1'b0, -1);
            check("R6 word_sync", word_sync, 1'b1, -1);
        end
        rst = 1'b0;

        for (int k = 0; k < NW * W + K + 1; k++) begin
            int wi;
            wi = k / W;
            a_bit = (wi < NW) ? av[wi][k % W] : 1'b0;
            b_bit = (wi < NW) ? bv[wi][k % W] : 1'b0;
            check("R1 word_sync", word_sync, ((k % W) == 0), k);
            @(negedge clk);
            if (k >= K) begin
                int ow;
                int ob;
                ow = (k - K) / W;
                ob = (k - K) % W;
                check("R3 y_sof", y_sof, (ob == 0), k);
                if (ow < NW) begin
                    if (ow == 4)
                        check("R4 carry clear", y_bit, ev[ow][ob], k);
                    else if (ow == 0 || ow == 1)
                        check("R5 sign extend", y_bit, ev[ow][ob], k);
                    else if (ow == 5 || ow == 6)
                        check("R7 floor", y_bit, ev[ow][ob], k);
                    else
                        check("R2 sum bit", y_bit, ev[ow][ob], k);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule